// File: doc/BRIEF.md
# Two-Agent MESI Coherence Home Agent

This block keeps a single 64-byte cache line coherent between two caches: a device cache that asks for the line, and a host cache that is snooped on its behalf. The device issues one of two request kinds: a read that will share the line, or a read for ownership. The agent answers a share read with a data snoop to the host. It answers an ownership read with an invalidating snoop. It learns the host's prior state from the snoop response. If the host held the line dirty, the agent writes that data to backing memory and waits for the acknowledge before it returns anything. Otherwise it reads the line from memory. It then grants the device a MESI state along with the line data.

The agent keeps its own copy of the state of both caches and handles one transaction at a time, holding off new requests while one is in flight. A device cache that holds the line Exclusive can upgrade to Modified on a local write without any snoop. The agent sees that write on a sideband strobe and updates its copy of the device state. Backing memory is a plain one-request, one-response port.

Top module: `mesi_home_agent`

## Requirements
- R1: After synchronous reset, req_ready is 1, both tracked states (dev_st, host_st) are Invalid, and snp_valid, mem_req_valid and rsp_valid are 0. States are encoded I=00, S=01, E=10, M=11 on every 2-bit state port.
- R2: A request accepted on a clock edge (req_valid and req_ready both high) produces a one-cycle snp_valid pulse in the next cycle. snp_inv is 0 for a share read (req_own=0) and 1 for an ownership read (req_own=1). No memory request is issued before the snoop response arrives.
- R3: Share read, host reports M: in the cycle after the snoop response, a memory write is issued carrying the snooped data. The response follows only after the memory acknowledge. It grants S, returns the snooped data and sets host_st to S.
- R4: Share read, host reports I: a memory read is issued with no write-back. The device is granted E with the memory data, and host_st stays I.
- R5: Share read, host reports S or E: a memory read is issued with no write-back. The device is granted S with the memory data, and host_st becomes S.
- R6: Ownership read, host reports I, S or E: a memory read is issued. The device is granted M with the memory data, and host_st becomes I.
- R7: Ownership read, host reports M: the snooped data is written back first. The device is then granted M with the snooped data, and host_st becomes I.
- R8: A dev_local_wr strobe while idle with dev_st at E moves dev_st to M on the next edge. No snoop and no memory request are issued.
- R9: A dev_local_wr strobe while dev_st is S or I leaves dev_st unchanged.
- R10: req_ready drops on the accept edge and rises again on the edge that raises rsp_valid, which lasts one cycle. Requests presented while req_ready is low start no snoop.
- R11: The tracked states never show E or M in one cache while the other is not I.
- R12: The line data ports (snoop data, memory data and response data) are LINE_BYTES*8 bits wide, 512 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Device request present |
| req_own | input | 1 | 1 = read for ownership, 0 = share read |
| req_ready | output | 1 | Agent idle and accepting a request |
| dev_local_wr | input | 1 | Device cache performed a local write |
| snp_valid | output | 1 | Snoop to host cache (one-cycle pulse) |
| snp_inv | output | 1 | 1 = invalidating snoop, 0 = data snoop |
| snp_rsp_valid | input | 1 | Snoop response present |
| snp_rsp_state | input | 2 | Host prior state |
| snp_rsp_data | input | LINE_BYTES*8 | Host line data (meaningful when prior is M) |
| mem_req_valid | output | 1 | Memory request pulse |
| mem_req_we | output | 1 | 1 = write-back, 0 = read |
| mem_wdata | output | LINE_BYTES*8 | Write-back data |
| mem_rsp_valid | input | 1 | Memory read data or write acknowledge |
| mem_rdata | input | LINE_BYTES*8 | Memory read data |
| rsp_valid | output | 1 | Grant and data to device (one cycle) |
| rsp_state | output | 2 | Granted state |
| rsp_data | output | LINE_BYTES*8 | Line data to device |
| dev_st | output | 2 | Tracked device-cache state |
| host_st | output | 2 | Tracked host-cache state |

## Verification
The assertions assume that snp_rsp_valid arrives only while the agent waits on a snoop and mem_rsp_valid only while it waits on memory. They also assume dev_local_wr is raised only while idle, and that the host's reported state agrees with the device's tracked state (a host reports I whenever the device holds E or M). The stimulus respects these assumptions by driving each response exactly once, in its wait window. It also chooses each host prior state to match the device state that the bench model holds, and it applies reset between scenarios instead of letting the device cache evict. Share reads are issued only from I, ownership reads only from I or S, and local writes only from E or M, apart from the deliberate ignored-write cases.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } mesi_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SWAIT = 2'd1,
    PH_MWAIT = 2'd2
  } phase_t;

  typedef struct packed {
    mesi_t grant;
    mesi_t peer_next;
    logic  wb;
  } outcome_t;

  // Outcome of a transaction from its kind and the peer's prior state
  function automatic outcome_t resolve(input logic own, input mesi_t peer);
    outcome_t o;
    o.wb = (peer == ST_M);
    if (own) begin
      o.grant     = ST_M;
      o.peer_next = ST_I;
    end else if (peer == ST_I) begin
      o.grant     = ST_E;
      o.peer_next = ST_I;
    end else begin
      o.grant     = ST_S;
      o.peer_next = ST_S;
    end
    return o;
  endfunction
endpackage

// File: rtl/ha_seq.sv
module ha_seq
  import mesi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       req_own,
  input  logic       snp_rsp_valid,
  input  logic [1:0] snp_rsp_state,
  input  logic       mem_rsp_valid,
  output logic       req_ready,
  output logic       snp_valid,
  output logic       snp_inv,
  output logic       mem_req_valid,
  output logic       mem_req_we,
  output logic       rsp_valid,
  output logic [1:0] rsp_state,
  output logic       cap_snoop,
  output logic       load_rsp,
  output logic       use_buf,
  output logic       commit,
  output mesi_t      commit_grant,
  output mesi_t      commit_peer
);
  phase_t   phase_q;
  logic     own_q;
  outcome_t out_q;
  outcome_t now_o;

  assign now_o     = resolve(own_q, mesi_t'(snp_rsp_state));
  assign cap_snoop = (phase_q == PH_SWAIT) && snp_rsp_valid && now_o.wb;
  assign load_rsp  = (phase_q == PH_MWAIT) && mem_rsp_valid;
  assign commit    = load_rsp;
  assign use_buf   = out_q.wb;
  assign commit_grant = out_q.grant;
  assign commit_peer  = out_q.peer_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q       <= PH_IDLE;
      own_q         <= 1'b0;
      out_q         <= '{grant: ST_I, peer_next: ST_I, wb: 1'b0};
      req_ready     <= 1'b1;
      snp_valid     <= 1'b0;
      snp_inv       <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_we    <= 1'b0;
      rsp_valid     <= 1'b0;
      rsp_state     <= ST_I;
    end else begin
      snp_valid     <= 1'b0;
      mem_req_valid <= 1'b0;
      rsp_valid     <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (req_valid) begin
            own_q     <= req_own;
            snp_valid <= 1'b1;
            snp_inv   <= req_own;
            req_ready <= 1'b0;
            phase_q   <= PH_SWAIT;
          end
        end
        PH_SWAIT: begin
          if (snp_rsp_valid) begin
            out_q         <= now_o;
            mem_req_valid <= 1'b1;
            mem_req_we    <= now_o.wb;
            phase_q       <= PH_MWAIT;
          end
        end
        PH_MWAIT: begin
          if (mem_rsp_valid) begin
            rsp_valid <= 1'b1;
            rsp_state <= out_q.grant;
            req_ready <= 1'b1;
            phase_q   <= PH_IDLE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ha_datapath.sv
module ha_datapath #(
  parameter int LINE_W = 512,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              cap_snoop,
  input  logic              load_rsp,
  input  logic              use_buf,
  input  logic [LINE_W-1:0] snp_data,
  input  logic [LINE_W-1:0] mem_rdata,
  output logic [LINE_W-1:0] wb_data,
  output logic [LINE_W-1:0] rsp_data
);
  localparam int NW = LINE_W / WORD_W;

  logic [WORD_W-1:0] buf_w [NW];
  logic [WORD_W-1:0] rsp_w [NW];

  for (genvar w = 0; w < NW; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (cap_snoop) buf_w[w] <= snp_data[w*WORD_W +: WORD_W];
      if (load_rsp)
        rsp_w[w] <= use_buf ? buf_w[w] : mem_rdata[w*WORD_W +: WORD_W];
    end
    assign wb_data[w*WORD_W +: WORD_W]  = buf_w[w];
    assign rsp_data[w*WORD_W +: WORD_W] = rsp_w[w];
  end
endmodule

// File: rtl/ha_dir.sv
module ha_dir
  import mesi_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  idle,
  input  logic  local_wr,
  input  logic  commit,
  input  mesi_t grant,
  input  mesi_t peer_next,
  output logic [1:0] dev_st,
  output logic [1:0] host_st
);
  mesi_t dev_q, host_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_q  <= ST_I;
      host_q <= ST_I;
    end else if (commit) begin
      dev_q  <= grant;
      host_q <= peer_next;
    end else if (idle && local_wr && dev_q == ST_E) begin
      dev_q <= ST_M;
    end
  end

  assign dev_st  = dev_q;
  assign host_st = host_q;
endmodule

// File: rtl/mesi_home_agent.sv
module mesi_home_agent
  import mesi_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int WORD_W     = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic                    req_own,
  output logic                    req_ready,
  input  logic                    dev_local_wr,
  output logic                    snp_valid,
  output logic                    snp_inv,
  input  logic                    snp_rsp_valid,
  input  logic [1:0]              snp_rsp_state,
  input  logic [LINE_BYTES*8-1:0] snp_rsp_data,
  output logic                    mem_req_valid,
  output logic                    mem_req_we,
  output logic [LINE_BYTES*8-1:0] mem_wdata,
  input  logic                    mem_rsp_valid,
  input  logic [LINE_BYTES*8-1:0] mem_rdata,
  output logic                    rsp_valid,
  output logic [1:0]              rsp_state,
  output logic [LINE_BYTES*8-1:0] rsp_data,
  output logic [1:0]              dev_st,
  output logic [1:0]              host_st
);
  localparam int LINE_W = LINE_BYTES * 8;

  logic  cap_snoop, load_rsp, use_buf, commit;
  mesi_t commit_grant, commit_peer;

  ha_seq u_seq (
    .clk, .rst, .req_valid, .req_own, .snp_rsp_valid, .snp_rsp_state,
    .mem_rsp_valid, .req_ready, .snp_valid, .snp_inv, .mem_req_valid,
    .mem_req_we, .rsp_valid, .rsp_state, .cap_snoop, .load_rsp, .use_buf,
    .commit, .commit_grant, .commit_peer
  );

  ha_datapath #(.LINE_W(LINE_W), .WORD_W(WORD_W)) u_dp (
    .clk, .cap_snoop, .load_rsp, .use_buf,
    .snp_data(snp_rsp_data), .mem_rdata,
    .wb_data(mem_wdata), .rsp_data
  );

  ha_dir u_dir (
    .clk, .rst, .idle(req_ready), .local_wr(dev_local_wr), .commit,
    .grant(commit_grant), .peer_next(commit_peer), .dev_st, .host_st
  );
endmodule

// File: rtl/ha_checker.sv
module ha_checker #(
  parameter int LINE_W = 512
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_own,
  input logic              req_ready,
  input logic              dev_local_wr,
  input logic              snp_valid,
  input logic              snp_inv,
  input logic              snp_rsp_valid,
  input logic [1:0]        snp_rsp_state,
  input logic [LINE_W-1:0] snp_rsp_data,
  input logic              mem_req_valid,
  input logic              mem_req_we,
  input logic [LINE_W-1:0] mem_wdata,
  input logic              rsp_valid,
  input logic [1:0]        rsp_state,
  input logic [1:0]        dev_st,
  input logic [1:0]        host_st
);
  // R2
  snoop_kind_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (snp_valid && snp_inv == $past(req_own)));

  // R2
  mem_after_snoop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req_valid) |-> $past(snp_rsp_valid));

  // R3
  wb_first_chk: assert property (@(posedge clk) disable iff (rst)
    (snp_rsp_valid && !req_ready && snp_rsp_state == 2'b11)
      |=> (mem_req_valid && mem_req_we && mem_wdata == $past(snp_rsp_data)));

  // R5
  clean_read_chk: assert property (@(posedge clk) disable iff (rst)
    (snp_rsp_valid && !req_ready && snp_rsp_state != 2'b11)
      |=> (mem_req_valid && !mem_req_we));

  // R4
  excl_sole_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_state == 2'b10) |-> (host_st == 2'b00));

  // R8
  silent_up_chk: assert property (@(posedge clk) disable iff (rst)
    (dev_local_wr && req_ready && !req_valid && dev_st == 2'b10)
      |=> (dev_st == 2'b11 && !snp_valid));

  // R10
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R10
  rsp_ready_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (req_ready && $fell(rsp_valid) == 1'b0));

  // R11
  single_owner_chk: assert property (@(posedge clk) disable iff (rst)
    ((dev_st[1] -> host_st == 2'b00) && (host_st[1] -> dev_st == 2'b00)));
endmodule

bind mesi_home_agent ha_checker #(.LINE_W(LINE_BYTES * 8)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_own(req_own),
  .req_ready(req_ready), .dev_local_wr(dev_local_wr), .snp_valid(snp_valid),
  .snp_inv(snp_inv), .snp_rsp_valid(snp_rsp_valid),
  .snp_rsp_state(snp_rsp_state), .snp_rsp_data(snp_rsp_data),
  .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
  .mem_wdata(mem_wdata), .rsp_valid(rsp_valid), .rsp_state(rsp_state),
  .dev_st(dev_st), .host_st(host_st)
);

// File: tb/tb_mesi_home_agent.sv
module tb_mesi_home_agent;
  localparam int LB = 64;
  localparam int LW = LB * 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic req_valid = 0, req_own = 0, dev_local_wr = 0;
  logic snp_rsp_valid = 0, mem_rsp_valid = 0;
  logic [1:0] snp_rsp_state = 0;
  logic [LW-1:0] snp_rsp_data = '0, mem_rdata = '0;
  logic req_ready, snp_valid, snp_inv, mem_req_valid, mem_req_we, rsp_valid;
  logic [1:0] rsp_state, dev_st, host_st;
  logic [LW-1:0] mem_wdata, rsp_data;

  mesi_home_agent #(.LINE_BYTES(LB)) dut (
    .clk, .rst, .req_valid, .req_own, .req_ready, .dev_local_wr,
    .snp_valid, .snp_inv, .snp_rsp_valid, .snp_rsp_state, .snp_rsp_data,
    .mem_req_valid, .mem_req_we, .mem_wdata, .mem_rsp_valid, .mem_rdata,
    .rsp_valid, .rsp_state, .rsp_data, .dev_st, .host_st
  );

  int total = 0, bad = 0, tag = 0;
  bit mon_en = 0, done = 0;
  logic exp_ready = 1;
  logic [1:0] exp_dev = 0, exp_host = 0;

  task automatic chk(input bit ok, input string req,
                     input logic [LW-1:0] act, input logic [LW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model compared every clock
  always @(posedge clk) begin
    #2;
    if (mon_en) begin
      chk(req_ready === exp_ready, "R10 ready", LW'(req_ready), LW'(exp_ready));
      chk(dev_st === exp_dev, "R11 dev state", LW'(dev_st), LW'(exp_dev));
      chk(host_st === exp_host, "R11 host state", LW'(host_st), LW'(exp_host));
    end
  end

  task automatic do_reset();
    mon_en = 0;
    rst = 1; req_valid = 0; dev_local_wr = 0; snp_rsp_valid = 0; mem_rsp_valid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    exp_ready = 1; exp_dev = 0; exp_host = 0;
    mon_en = 1;
    @(negedge clk);
    chk(req_ready === 1 && dev_st === 0 && host_st === 0, "R1 reset state",
        LW'({req_ready, dev_st, host_st}), LW'(5'b10000));
    chk(!snp_valid && !mem_req_valid && !rsp_valid, "R1 outputs idle",
        LW'({snp_valid, mem_req_valid, rsp_valid}), '0);
  endtask

  // Expected grant and host next state, from the requirement tables
  function automatic logic [3:0] expect_out(input bit own, input logic [1:0] prior);
    if (own) return {2'b11, 2'b00};
    case (prior)
      2'b00:   return {2'b10, 2'b00};
      default: return {2'b01, 2'b01};
    endcase
  endfunction

  task automatic txn(input bit own, input logic [1:0] prior,
                     input int mem_lat, input bit press);
    logic [LW-1:0] sdata, mdata;
    logic [3:0] eo;
    string tg;
    tag++;
    sdata = {16{32'h5A00_0000 + tag}};
    mdata = {16{32'hC300_0000 + tag}};
    eo = expect_out(own, prior);
    if (own) tg = (prior == 2'b11) ? "R7" : "R6";
    else tg = (prior == 2'b11) ? "R3" : (prior == 2'b00) ? "R4" : "R5";

    @(negedge clk); req_valid = 1; req_own = own;
    @(posedge clk); exp_ready = 0;
    @(negedge clk); req_valid = 0;
    chk(snp_valid === 1 && snp_inv === own, "R2 snoop kind",
        LW'({snp_valid, snp_inv}), LW'({1'b1, own}));
    chk(mem_req_valid === 0, "R2 no memory before snoop", LW'(mem_req_valid), '0);
    snp_rsp_valid = 1; snp_rsp_state = prior; snp_rsp_data = sdata;
    @(negedge clk); snp_rsp_valid = 0;
    chk(snp_valid === 0, "R2 snoop pulse", LW'(snp_valid), '0);
    chk(mem_req_valid === 1 && mem_req_we === (prior == 2'b11), {tg, " memory op"},
        LW'({mem_req_valid, mem_req_we}), LW'({1'b1, prior == 2'b11}));
    if (prior == 2'b11) chk(mem_wdata === sdata, {tg, " write-back data"}, mem_wdata, sdata);
    chk(rsp_valid === 0, {tg, " no data before memory"}, LW'(rsp_valid), '0);
    if (press) begin req_valid = 1; req_own = !own; end
    for (int i = 0; i < mem_lat; i++) begin
      @(negedge clk);
      chk(!rsp_valid && !snp_valid && !mem_req_valid, "R10 quiet while busy",
          LW'({rsp_valid, snp_valid, mem_req_valid}), '0);
    end
    req_valid = 0;
    mem_rsp_valid = 1; mem_rdata = mdata;
    @(posedge clk);
    exp_ready = 1; exp_dev = eo[3:2]; exp_host = eo[1:0];
    @(negedge clk); mem_rsp_valid = 0;
    chk(rsp_valid === 1 && rsp_state === eo[3:2], {tg, " grant"},
        LW'({rsp_valid, rsp_state}), LW'({1'b1, eo[3:2]}));
    chk(rsp_data === ((prior == 2'b11) ? sdata : mdata), {tg, " data"},
        rsp_data, (prior == 2'b11) ? sdata : mdata);
    @(negedge clk);
    chk(rsp_valid === 0 && snp_valid === 0, "R10 single response",
        LW'({rsp_valid, snp_valid}), '0);
  endtask

  task automatic local_write(input string tg);
    @(negedge clk); dev_local_wr = 1;
    @(posedge clk); if (exp_dev == 2'b10) exp_dev = 2'b11;
    @(negedge clk); dev_local_wr = 0;
    chk(!snp_valid && !mem_req_valid, "R8 no traffic on local write",
        LW'({snp_valid, mem_req_valid}), '0);
    chk(dev_st === exp_dev, tg, LW'(dev_st), LW'(exp_dev));
  endtask

  initial begin
    do_reset();
    txn(0, 2'b11, 2, 0);          // R3
    txn(1, 2'b01, 1, 0);          // R6 from S
    local_write("R8 M stays M");
    do_reset();
    txn(0, 2'b00, 3, 0);          // R4
    local_write("R8 E to M");
    do_reset();
    txn(0, 2'b10, 1, 0);          // R5 peer E
    local_write("R9 write in S ignored");
    txn(1, 2'b01, 2, 1);          // R6 with backpressure
    do_reset();
    txn(1, 2'b11, 4, 0);          // R7
    do_reset();
    local_write("R9 write in I ignored");
    txn(1, 2'b00, 1, 0);          // R6 peer I
    do_reset();
    txn(1, 2'b10, 2, 0);          // R6 peer E
    do_reset();
    txn(0, 2'b01, 3, 1);          // R5 peer S, R10 backpressure
    chk($bits(rsp_data) == 512, "R12 line width", LW'($bits(rsp_data)), LW'(512));
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule